// File: doc/BRIEF.md
# Edge-Configurable External Interrupt Controller

This block watches a parameterised set of external input lines (sixteen by default) and turns transitions on them into latched pending flags and per-line interrupt pulses. Every line runs through a two-flop synchroniser. An edge is detected by comparing the synchronised value with its value one cycle earlier. Two independent select registers decide, line by line, whether a rising transition, a falling transition or both count as an event.

A detected event sets the line's pending flag whatever the interrupt mask holds. The mask only gates the one-cycle pulse on that line's own interrupt output. Software sees the block through a plain 32-bit register port (address, write strobe, write data, read strobe, read data) plus a one-cycle error flag for accesses that miss the map. Software can also fire any line through a trigger register. Pending flags are cleared by writing ones.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register (interrupt mask, event mask, rising select, falling select, software trigger, pending) reads zero, and the interrupt outputs and error flag are low.
- R2: A line with its rising-select bit set gets its pending bit set on the third rising clock edge after its input goes from 0 to 1. This covers two synchroniser stages and one pending register.
- R3: A line with its falling-select bit set gets its pending bit set on the third rising clock edge after its input goes from 1 to 0.
- R4: A transition on a line whose select bit for that direction is clear leaves its pending bit at zero.
- R5: The pending bit is latched even when the line's interrupt-mask bit is 0, and such a line never pulses its interrupt output.
- R6: When the mask bit is 1, each event gives a pulse exactly one clock wide on that line's `irq_pulse` bit, high in the same cycle the pending bit first reads set.
- R7: Writing to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: If an event and a write-1-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R9: Writing 1 over a 0 in the software-trigger register sets the pending bit and, if unmasked, pulses the output in the cycle after the write. Rewriting a 1 or writing 0 does nothing. A trigger bit clears itself when its pending bit is cleared.
- R10: Accesses that map to no register, or are not word aligned, anywhere in the 1 KiB window have no effect and raise `bus_err` for one cycle. A read of such an offset returns zero.
- R11: Register bits at or above the line count read as zero and ignore writes.
- R12: Byte offsets are 0x00 interrupt mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. Read data is valid in the cycle after the read strobe and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous external lines |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_err | output | 1 | One-cycle flag for an unmapped access |
| irq_pulse | output | NUM_LINES | Per-line one-cycle interrupt pulses |

## Verification
The hardest situation to reach is a line event landing in exactly the cycle a write-1-to-clear reaches the same pending bit. The edge has to cross the synchroniser first, so the stimulus changes the line and then counts two clock edges before presenting the clear write. The event and the clear therefore meet at the pending register on the same edge. The self-clearing software trigger is also hard to reach, because it is only visible by reading the trigger register back after a pending clear. The bench fires the trigger, rewrites it, writes zero to it and clears one of two pending bits, reading both registers after each step.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    SEL_IMASK, SEL_EMASK, SEL_RISE, SEL_FALL, SEL_SWTRIG, SEL_PEND, SEL_NONE
  } reg_sel_e;

  // Byte offset to register select; unaligned or unmapped gives SEL_NONE.
  function automatic reg_sel_e decode_offset(input logic [REG_W-1:0] ofs);
    case (ofs)
      32'h00:  return SEL_IMASK;
      32'h04:  return SEL_EMASK;
      32'h08:  return SEL_RISE;
      32'h0C:  return SEL_FALL;
      32'h10:  return SEL_SWTRIG;
      32'h14:  return SEL_PEND;
      default: return SEL_NONE;
    endcase
  endfunction

  // Qualifying transition on a single line.
  function automatic logic edge_hit(input logic cur, input logic prev,
                                    input logic rise_en, input logic fall_en);
    return (cur & ~prev & rise_en) | (~cur & prev & fall_en);
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int NUM_LINES = 16,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] cur_o,
  output logic [NUM_LINES-1:0] prev_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], line_in[i]};
    end
    assign cur_o[i]  = chain[STAGES-1];
    assign prev_o[i] = chain[STAGES];
  end
endmodule

// File: rtl/eic_pending.sv
module eic_pending #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hw_set_i,
  input  logic [NUM_LINES-1:0] sw_set_i,
  input  logic [NUM_LINES-1:0] clr_req_i,
  input  logic [NUM_LINES-1:0] imask_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic [NUM_LINES-1:0] clr_done_o
);
  logic [NUM_LINES-1:0] set_all;

  assign set_all    = hw_set_i | sw_set_i;
  assign clr_done_o = clr_req_i & ~set_all;   // a same-cycle event wins

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      irq_o  <= '0;
    end else begin
      pend_o <= (pend_o & ~clr_done_o) | set_all;
      irq_o  <= set_all & imask_i;
    end
  end

  p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_all) & ~pend_o) == '0))
    else $error("event did not leave pending set");

  p_no_silent_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_o) & ~pend_o & ~$past(clr_req_i)) == '0))
    else $error("pending bit dropped without a clear");

  p_pulse_with_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~pend_o) == '0))
    else $error("pulse without pending bit");
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [REG_W-1:0]     bus_wdata,
  input  logic                 bus_rd,
  output logic [REG_W-1:0]     bus_rdata,
  output logic                 bus_err,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] clr_done_i,
  output logic [NUM_LINES-1:0] imask_o,
  output logic [NUM_LINES-1:0] rise_sel_o,
  output logic [NUM_LINES-1:0] fall_sel_o,
  output logic [NUM_LINES-1:0] sw_q_o,
  output logic [NUM_LINES-1:0] sw_set_o,
  output logic [NUM_LINES-1:0] clr_req_o
);
  logic [NUM_LINES-1:0] emask_q;
  logic [NUM_LINES-1:0] wdata_n;
  logic [REG_W-1:0]     ofs;
  logic [REG_W-1:0]     rd_val;
  reg_sel_e             sel;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wdata_n      = bus_wdata[NUM_LINES-1:0];

  always_comb begin
    ofs = '0;
    ofs[ADDR_W-1:0] = bus_addr;
    sel = decode_offset(ofs);
  end

  assign sw_set_o  = (bus_wr && sel == SEL_SWTRIG) ? (wdata_n & ~sw_q_o) : '0;
  assign clr_req_o = (bus_wr && sel == SEL_PEND)   ? wdata_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_o    <= '0;
      emask_q    <= '0;
      rise_sel_o <= '0;
      fall_sel_o <= '0;
      sw_q_o     <= '0;
    end else begin
      if (bus_wr && sel == SEL_IMASK) imask_o    <= wdata_n;
      if (bus_wr && sel == SEL_EMASK) emask_q    <= wdata_n;
      if (bus_wr && sel == SEL_RISE)  rise_sel_o <= wdata_n;
      if (bus_wr && sel == SEL_FALL)  fall_sel_o <= wdata_n;
      sw_q_o <= (sw_q_o | sw_set_o) & ~clr_done_i;
    end
  end

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_IMASK:  rd_val[NUM_LINES-1:0] = imask_o;
      SEL_EMASK:  rd_val[NUM_LINES-1:0] = emask_q;
      SEL_RISE:   rd_val[NUM_LINES-1:0] = rise_sel_o;
      SEL_FALL:   rd_val[NUM_LINES-1:0] = fall_sel_o;
      SEL_SWTRIG: rd_val[NUM_LINES-1:0] = sw_q_o;
      SEL_PEND:   rd_val[NUM_LINES-1:0] = pend_i;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      bus_err   <= (bus_rd || bus_wr) && (sel == SEL_NONE);
    end
  end

  p_err_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0))
    else $error("unmapped access returned data");

  p_idle_rdata_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == '0))
    else $error("read data without a read strobe");

  if (NUM_LINES < REG_W) begin : g_hi_chk
    p_high_bits_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[REG_W-1:NUM_LINES] == '0))
      else $error("bits above line count read nonzero");
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_LINES-1:0] irq_pulse
);
  logic [NUM_LINES-1:0] line_cur, line_prev, hw_set;
  logic [NUM_LINES-1:0] imask, rise_sel, fall_sel, sw_q, sw_set;
  logic [NUM_LINES-1:0] clr_req, clr_done, pend;

  eic_sync #(.NUM_LINES(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .cur_o(line_cur), .prev_o(line_prev)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
    assign hw_set[i] = edge_hit(line_cur[i], line_prev[i], rise_sel[i], fall_sel[i]);
  end

  eic_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pend_i(pend), .clr_done_i(clr_done),
    .imask_o(imask), .rise_sel_o(rise_sel), .fall_sel_o(fall_sel),
    .sw_q_o(sw_q), .sw_set_o(sw_set), .clr_req_o(clr_req)
  );

  eic_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .hw_set_i(hw_set), .sw_set_i(sw_set), .clr_req_i(clr_req),
    .imask_i(imask), .pend_o(pend), .irq_o(irq_pulse), .clr_done_o(clr_done)
  );

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_pulse & ~$past(imask)) == '0))
    else $error("masked line pulsed");

  p_hw_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((pend & $past(hw_set)) == $past(hw_set)))
    else $error("line event not latched");

  p_sw_within_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_q & ~pend) == '0))
    else $error("trigger bit outlived its pending bit");
endmodule

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam logic [15:0] IMASK = 16'h3333;
  localparam logic [15:0] RSEL  = 16'h0F0F;
  localparam logic [15:0] FSEL  = 16'h00FF;
  // {line value [31:16], expected pending [15:0]}
  localparam logic [31:0] VECS [7] = '{
    32'hFFFF_0F0F, 32'h0000_00FF, 32'h5555_0505, 32'hAAAA_0A5F,
    32'hAAAA_0000, 32'hF0F0_000A, 32'h0000_00F0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] line_in = '0;
  logic [9:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [N-1:0] irq_pulse;
  int checks = 0, errors = 0;
  logic last_err;
  logic [31:0] rv;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    last_err = bus_err; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; last_err = bus_err; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    check("R1 irq", {16'h0, irq_pulse}, 32'h0);
    check("R1 err", {31'h0, bus_err}, 32'h0);
    for (int k = 0; k < 6; k++) begin
      rd(10'(k*4), rv);
      check("R1 reg", rv, 32'h0);
    end
    // R11/R12: register layout and width
    wr(10'h08, 32'hFFFF_FFFF); rd(10'h08, rv); check("R11 rise width", rv, 32'h0000_FFFF);
    wr(10'h04, 32'hABCD_1234); rd(10'h04, rv); check("R12 event mask", rv, 32'h0000_1234);
    check("R12 mapped no err", {31'h0, last_err}, 32'h0);
    wr(10'h00, {16'h0, IMASK}); wr(10'h08, {16'h0, RSEL}); wr(10'h0C, {16'h0, FSEL});
    rd(10'h00, rv); check("R12 imask", rv, {16'h0, IMASK});
    rd(10'h0C, rv); check("R12 fall", rv, {16'h0, FSEL});
    @(negedge clk);
    check("R12 idle rdata", bus_rdata, 32'h0);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 7; v++) begin
      wr(10'h14, 32'h0000_FFFF);
      line_in = VECS[v][31:16];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6 pulse", {16'h0, irq_pulse}, {16'h0, VECS[v][15:0] & IMASK});
      @(negedge clk);
      check("R6 one cycle", {16'h0, irq_pulse}, 32'h0);
      rd(10'h14, rv);
      check("R2 R3 R4 R5 pending", rv, {16'h0, VECS[v][15:0]});
    end
    wr(10'h14, 32'h0000_FFFF);

    // R7: partial clear
    line_in = 16'h0003;
    repeat (3) @(posedge clk);
    rd(10'h14, rv); check("R2 rise pend", rv, 32'h0003);
    wr(10'h14, 32'h0000_0000); rd(10'h14, rv); check("R7 zero keeps", rv, 32'h0003);
    wr(10'h14, 32'h0000_0002); rd(10'h14, rv); check("R7 one clears", rv, 32'h0001);
    wr(10'h14, 32'h0000_0002);

    // R8: fall event on line 0 meets clear of lines 0 and 1
    line_in = 16'h0003;
    wr(10'h14, 32'h0000_FFFF);
    line_in = 16'h0001;               // line 1 falls: sets bit1
    repeat (3) @(posedge clk);
    rd(10'h14, rv); check("R3 fall pend", rv, 32'h0002);
    @(negedge clk);
    line_in = 16'h0000;               // line 0 falls
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_addr = 10'h14; bus_wdata = 32'h0000_0003; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 pulse", {16'h0, irq_pulse}, 32'h0001);
    rd(10'h14, rv); check("R8 edge wins", rv, 32'h0001);
    wr(10'h14, 32'h0000_FFFF);

    // R9: software trigger
    wr(10'h10, 32'h0000_0005);
    check("R9 sw pulse", {16'h0, irq_pulse}, 32'h0001);
    rd(10'h14, rv); check("R9 sw pend", rv, 32'h0005);
    rd(10'h10, rv); check("R9 sw reg", rv, 32'h0005);
    wr(10'h10, 32'h0000_0005);
    check("R9 rewrite no pulse", {16'h0, irq_pulse}, 32'h0);
    wr(10'h10, 32'h0000_0000); rd(10'h10, rv); check("R9 write zero", rv, 32'h0005);
    wr(10'h14, 32'h0000_0001);
    rd(10'h10, rv); check("R9 self clear", rv, 32'h0004);
    rd(10'h14, rv); check("R9 pend after clear", rv, 32'h0004);
    wr(10'h10, 32'h0000_0001);
    check("R9 refire", {16'h0, irq_pulse}, 32'h0001);

    // R10: unmapped and unaligned
    rd(10'h018, rv); check("R10 read zero", rv, 32'h0);
    check("R10 err", {31'h0, last_err}, 32'h1);
    @(negedge clk); check("R10 err one cycle", {31'h0, bus_err}, 32'h0);
    wr(10'h3FC, 32'hFFFF_FFFF); check("R10 write err", {31'h0, last_err}, 32'h1);
    rd(10'h002, rv); check("R10 unaligned", {rv[30:0], last_err}, 32'h1);
    rd(10'h08, rv); check("R10 no side effect", rv, {16'h0, RSEL});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule